// File: doc/BRIEF.md
# Address-Matching Neuron Accumulator Cell

This block is a single neuron computing cell. Every cell in a neural computing unit sees the same 16-bit broadcast word. The word carries the index of the cell that produced a value and that value. Each cell holds a small decoder table. A table row pairs a source address with a signed weight and has a valid bit. The cell compares the incoming index with all rows in parallel. On a hit it multiplies the stored weight by the incoming value and adds the product into a saturating 20-bit running sum, all in the same clock cycle. Addressing and computing therefore happen inside the cell, and no crossbar or synapse memory is needed.

A global synchronisation pulse closes the accumulation period. On that pulse the cell copies the running sum, including any product arriving in the same cycle, into an output buffer and clears the sum. The buffer carries a valid flag. The flag is raised only when the period saw at least one hit, and it is dropped when downstream transmission logic takes the result. The table is loaded through a plain write port with an enable, a row index and the row contents.

Two small state machines form the control. The period machine has two states:
- `P_QUIET`: no hit yet in this period.
- `P_ACTIVE`: at least one hit in this period.

It moves from `P_QUIET` to `P_ACTIVE` on a hit without sync, and returns to `P_QUIET` on any sync.

The buffer machine also has two states:
- `B_EMPTY`: no unread result.
- `B_READY`: a result is waiting to be read.

It moves to `B_READY` on a sync that closes a period with hits. It moves to `B_EMPTY` on a sync that closes a period without hits, or on a take with no sync in the same cycle.

Top module: `nacc_cell`

## Requirements
- R1: After reset, `out_valid` is 0, `out_sum` is 0 and every table row is invalid, so no broadcast can hit until a row is written.
- R2: A broadcast is accepted when `bc_valid` is 1. Bits [15:8] of `bc_data` are the source index and bits [7:0] are the value as a signed two's-complement byte.
- R3: When `tbl_we` is 1, row `tbl_idx` takes `tbl_addr`, `tbl_wgt` (signed) and `tbl_vld` at the clock edge. A broadcast in the same cycle is compared against the table contents from before the write.
- R4: A hit adds the signed 16-bit product of the row weight and the broadcast value to the running sum.
- R5: A broadcast whose index matches no valid row, or a cycle with `bc_valid` at 0, leaves the running sum unchanged.
- R6: When several valid rows hold the index, only the row with the lowest number contributes, and it contributes once.
- R7: The running sum saturates at +524287 and at -524288 instead of wrapping.
- R8: On `sync_pulse`, `out_sum` takes the running sum plus any same-cycle hit product, and the running sum restarts at 0.
- R9: On `sync_pulse`, `out_valid` becomes 1 if the closing period (including the sync cycle) had at least one hit. Otherwise it becomes 0 and `out_sum` reads 0.
- R10: `out_take` clears `out_valid` without changing `out_sum`. If `sync_pulse` arrives in the same cycle, the sync result wins.
- R11: A row whose valid bit is 0 never matches, whatever address it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_we | input | 1 | Table row write enable |
| tbl_idx | input | 3 | Row number to write |
| tbl_addr | input | 8 | Source address stored in the row |
| tbl_wgt | input | 8 | Signed weight stored in the row |
| tbl_vld | input | 1 | Valid bit stored in the row |
| bc_valid | input | 1 | Broadcast word present |
| bc_data | input | 16 | Source index [15:8], signed value [7:0] |
| sync_pulse | input | 1 | Global synchronisation pulse that closes the period |
| out_take | input | 1 | Downstream has consumed the buffered result |
| out_valid | output | 1 | Buffered result is valid |
| out_sum | output | 20 | Buffered signed sum |

## Verification
The running sum is only visible after a sync. A corrupted accumulator, a wrong product or a missed or duplicated hit therefore shows up as a wrong `out_sum` on the cycle after the next `sync_pulse`, and not before. A wrong period state shows up on that same cycle as `out_valid` being set after a period with no hits, or staying clear after one with hits. A wrong buffer state shows up one cycle after `out_take`, when the flag stays high. A table write that lands in the wrong row, or lands too early, changes which broadcasts hit, and that difference appears only in the next sync result.

// File: rtl/nacc_pkg.sv
package nacc_pkg;

    typedef enum logic {
        P_QUIET  = 1'b0,
        P_ACTIVE = 1'b1
    } period_state_t;

    typedef enum logic {
        B_EMPTY = 1'b0,
        B_READY = 1'b1
    } buf_state_t;

endpackage

// File: rtl/nacc_table.sv
module nacc_table #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned WGT_W   = 8,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic signed [WGT_W-1:0] wr_wgt,
    input  logic                    wr_vld,
    input  logic                    look_en,
    input  logic [ADDR_W-1:0]       look_addr,
    output logic                    hit,
    output logic signed [WGT_W-1:0] hit_wgt
);

    logic [ENTRIES-1:0]            row_vld;
    logic [ENTRIES-1:0][ADDR_W-1:0] row_addr;
    logic [ENTRIES-1:0][WGT_W-1:0]  row_wgt;
    logic [ENTRIES-1:0]            match;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_row
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    row_vld[g]  <= 1'b0;
                    row_addr[g] <= '0;
                    row_wgt[g]  <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    row_vld[g]  <= wr_vld;
                    row_addr[g] <= wr_addr;
                    row_wgt[g]  <= wr_wgt;
                end
            end

            assign match[g] = look_en && row_vld[g] && (row_addr[g] == look_addr);
        end
    endgenerate

    // lowest-numbered matching row wins
    always_comb begin
        hit     = 1'b0;
        hit_wgt = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_wgt = row_wgt[i];
            end
        end
    end

endmodule

// File: rtl/nacc_mac.sv
module nacc_mac #(
    parameter int unsigned WGT_W = 8,
    parameter int unsigned VAL_W = 8,
    parameter int unsigned ACC_W = 20,
    localparam int unsigned PRD_W = WGT_W + VAL_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hit,
    input  logic signed [WGT_W-1:0] wgt,
    input  logic signed [VAL_W-1:0] val,
    input  logic                    clear,
    output logic signed [ACC_W-1:0] acc,
    output logic signed [ACC_W-1:0] acc_next
);

    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [PRD_W-1:0] prod;
    logic signed [ACC_W:0]   wide;
    logic signed [ACC_W-1:0] sat_sum;

    always_comb begin
        prod = wgt * val;
        wide = $signed({acc[ACC_W-1], acc}) + (ACC_W+1)'(prod);
        if (wide[ACC_W] != wide[ACC_W-1]) begin
            sat_sum = wide[ACC_W] ? ACC_MIN : ACC_MAX;
        end else begin
            sat_sum = wide[ACC_W-1:0];
        end
        acc_next = hit ? sat_sum : acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clear) begin
            acc <= '0;
        end else begin
            acc <= acc_next;
        end
    end

endmodule

// File: rtl/nacc_ctrl.sv
module nacc_ctrl
    import nacc_pkg::*;
#(
    parameter int unsigned ACC_W = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hit,
    input  logic                    sync,
    input  logic                    take,
    input  logic signed [ACC_W-1:0] sum_in,
    output logic                    out_valid,
    output logic [ACC_W-1:0]        out_sum
);

    period_state_t per_q, per_d;
    buf_state_t    buf_q, buf_d;
    logic [ACC_W-1:0] sum_q, sum_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q <= P_QUIET;
            buf_q <= B_EMPTY;
            sum_q <= '0;
        end else begin
            per_q <= per_d;
            buf_q <= buf_d;
            sum_q <= sum_d;
        end
    end

    always_comb begin
        per_d = per_q;
        buf_d = buf_q;
        sum_d = sum_q;
        unique case (per_q)
            P_QUIET:  if (!sync && hit) per_d = P_ACTIVE;
            P_ACTIVE: if (sync)         per_d = P_QUIET;
            default:  per_d = P_QUIET;
        endcase
        if (sync) begin
            sum_d = sum_in;
            buf_d = (hit || (per_q == P_ACTIVE)) ? B_READY : B_EMPTY;
        end else begin
            unique case (buf_q)
                B_EMPTY: buf_d = B_EMPTY;
                B_READY: if (take) buf_d = B_EMPTY;
                default: buf_d = B_EMPTY;
            endcase
        end
    end

    assign out_valid = (buf_q == B_READY);
    assign out_sum   = sum_q;

endmodule

// File: rtl/nacc_cell.sv
module nacc_cell #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned VAL_W   = 8,
    parameter int unsigned WGT_W   = 8,
    parameter int unsigned ACC_W   = 20,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int unsigned BC_W   = ADDR_W + VAL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic [WGT_W-1:0]  tbl_wgt,
    input  logic              tbl_vld,
    input  logic              bc_valid,
    input  logic [BC_W-1:0]   bc_data,
    input  logic              sync_pulse,
    input  logic              out_take,
    output logic              out_valid,
    output logic [ACC_W-1:0]  out_sum
);

    logic                    hit;
    logic signed [WGT_W-1:0] hit_wgt;
    logic [ADDR_W-1:0]       src_idx;
    logic signed [VAL_W-1:0] src_val;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] acc_next;

    assign src_idx = bc_data[BC_W-1:VAL_W];
    assign src_val = $signed(bc_data[VAL_W-1:0]);

    nacc_table #(
        .ENTRIES(ENTRIES),
        .ADDR_W (ADDR_W),
        .WGT_W  (WGT_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_idx   (tbl_idx),
        .wr_addr  (tbl_addr),
        .wr_wgt   ($signed(tbl_wgt)),
        .wr_vld   (tbl_vld),
        .look_en  (bc_valid),
        .look_addr(src_idx),
        .hit      (hit),
        .hit_wgt  (hit_wgt)
    );

    nacc_mac #(
        .WGT_W(WGT_W),
        .VAL_W(VAL_W),
        .ACC_W(ACC_W)
    ) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .wgt     (hit_wgt),
        .val     (src_val),
        .clear   (sync_pulse),
        .acc     (acc_q),
        .acc_next(acc_next)
    );

    nacc_ctrl #(
        .ACC_W(ACC_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .sync     (sync_pulse),
        .take     (out_take),
        .sum_in   (acc_next),
        .out_valid(out_valid),
        .out_sum  (out_sum)
    );

endmodule

// File: rtl/nacc_cell_chk.sv
module nacc_cell_chk #(
    parameter int unsigned ACC_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bc_valid,
    input logic             sync,
    input logic             out_take,
    input logic             out_valid,
    input logic [ACC_W-1:0] out_sum,
    input logic [ACC_W-1:0] acc
);

    // R5
    idle_acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bc_valid && !sync) |=> $stable(acc));

    // R8
    sync_clears_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (acc == '0));

    // R8
    sum_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync |=> $stable(out_sum));

    // R9
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(sync));

    // R10
    take_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_take && !sync) |=> !out_valid);

endmodule

bind nacc_cell nacc_cell_chk #(.ACC_W(ACC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bc_valid (bc_valid),
    .sync     (sync_pulse),
    .out_take (out_take),
    .out_valid(out_valid),
    .out_sum  (out_sum),
    .acc      (acc_q)
);

// File: tb/test_nacc_cell.sv
module test_nacc_cell;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [2:0]  tbl_idx = '0;
    logic [7:0]  tbl_addr = '0;
    logic [7:0]  tbl_wgt = '0;
    logic        tbl_vld = 1'b0;
    logic        bc_valid = 1'b0;
    logic [15:0] bc_data = '0;
    logic        sync_pulse = 1'b0;
    logic        out_take = 1'b0;
    logic        out_valid;
    logic [19:0] out_sum;

    int n_total = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model
    bit m_vld [8];
    int m_addr [8];
    int m_wgt [8];
    int m_acc = 0;
    bit m_seen = 0;
    int m_osum = 0;
    bit m_ovld = 0;

    always #2.5 clk = ~clk;

    nacc_cell i_nacc_cell (
        .clk(clk), .rst_n(rst_n),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_addr(tbl_addr),
        .tbl_wgt(tbl_wgt), .tbl_vld(tbl_vld),
        .bc_valid(bc_valid), .bc_data(bc_data),
        .sync_pulse(sync_pulse), .out_take(out_take),
        .out_valid(out_valid), .out_sum(out_sum)
    );

    function automatic int sat20(int v);
        if (v > 524287) return 524287;
        if (v < -524288) return -524288;
        return v;
    endfunction

    function automatic int sbyte(logic [7:0] b);
        return int'($signed(b));
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_step();
        bit hitnow = 0;
        int w = 0;
        if (bc_valid) begin
            for (int i = 7; i >= 0; i--) begin
                if (m_vld[i] && m_addr[i] == int'(bc_data[15:8])) begin
                    hitnow = 1;
                    w = m_wgt[i];
                end
            end
        end
        if (hitnow) m_acc = sat20(m_acc + w * sbyte(bc_data[7:0]));
        if (sync_pulse) begin
            m_osum = m_acc;
            m_ovld = m_seen | hitnow;
            m_acc = 0;
            m_seen = 0;
        end else begin
            if (hitnow) m_seen = 1;
            if (out_take) m_ovld = 0;
        end
        if (tbl_we) begin
            m_vld[tbl_idx]  = tbl_vld;
            m_addr[tbl_idx] = int'(tbl_addr);
            m_wgt[tbl_idx]  = sbyte(tbl_wgt);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        tbl_we = 0; bc_valid = 0; sync_pulse = 0; out_take = 0;
    endtask

    task automatic wr(int idx, int addr, int wgt, bit vld);
        tbl_we = 1; tbl_idx = 3'(idx); tbl_addr = 8'(addr);
        tbl_wgt = 8'(wgt); tbl_vld = vld;
        tick();
    endtask

    task automatic bc(int addr, int val);
        bc_valid = 1; bc_data = {8'(addr), 8'(val)};
        tick();
    endtask

    task automatic do_sync();
        sync_pulse = 1;
        tick();
    endtask

    task automatic expect_out(string req, bit ev, int es);
        check(out_valid == ev, req, int'(out_valid), int'(ev));
        check($signed(out_sum) == es, req, int'($signed(out_sum)), es);
    endtask

    initial begin
        #500000;
        n_total++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_vld[i] = 0; m_addr[i] = 0; m_wgt[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        expect_out("R1", 0, 0);
        bc(8'h00, 5);
        do_sync();
        expect_out("R1 no hit on empty table", 0, 0);

        // R2 R4 R5 basic accumulate
        wr(0, 8'h12, 5, 1);
        wr(1, 8'h34, -3, 1);
        bc(8'h12, 10);
        bc(8'h34, -7);
        bc(8'h55, 99);
        bc(8'h10, 8'h12);
        do_sync();
        expect_out("R4", 1, 71);

        // R10 take clears flag only
        out_take = 1;
        tick();
        expect_out("R10", 0, 71);

        // R9 empty period
        bc(8'h56, 3);
        do_sync();
        expect_out("R9", 0, 0);

        // R6 duplicates; R8 hit in sync cycle counted
        wr(2, 8'h12, 100, 1);
        bc(8'h12, 1);
        bc_valid = 1; bc_data = {8'h12, 8'd2}; sync_pulse = 1;
        tick();
        expect_out("R6", 1, 15);

        // R8 acc restarted: only new hit visible
        bc(8'h34, 1);
        do_sync();
        expect_out("R8", 1, -3);

        // R3 write and broadcast same cycle
        tbl_we = 1; tbl_idx = 3'd0; tbl_addr = 8'h77; tbl_wgt = 8'd5; tbl_vld = 1;
        bc_valid = 1; bc_data = {8'h77, 8'd9};
        tick();
        bc(8'h77, 2);
        do_sync();
        expect_out("R3", 1, 10);

        // R7 positive and negative saturation
        wr(3, 8'h80, 127, 1);
        for (int i = 0; i < 40; i++) bc(8'h80, 127);
        do_sync();
        expect_out("R7 max", 1, 524287);
        for (int i = 0; i < 40; i++) bc(8'h80, -128);
        do_sync();
        expect_out("R7 min", 1, -524288);

        // R11 invalid row
        wr(3, 8'h80, 127, 0);
        bc(8'h80, 5);
        do_sync();
        expect_out("R11", 0, 0);

        // R10 sync and take together: sync wins
        bc(8'h34, 2);
        sync_pulse = 1; out_take = 1;
        tick();
        expect_out("R10 sync priority", 1, -6);

        // random mix against model
        begin
            void'($urandom(32'd4242));
            for (int c = 0; c < 3000; c++) begin
                int r = int'($urandom_range(0, 99));
                if (r < 5) begin
                    tbl_we = 1; tbl_idx = 3'($urandom_range(0, 7));
                    tbl_addr = 8'($urandom_range(8'h20, 8'h25));
                    tbl_wgt = 8'($urandom); tbl_vld = ($urandom_range(0, 3) != 0);
                end
                if ($urandom_range(0, 99) < 70) begin
                    bc_valid = 1;
                    bc_data = {8'($urandom_range(8'h20, 8'h27)), 8'($urandom)};
                end
                if ($urandom_range(0, 99) < 6) sync_pulse = 1;
                if ($urandom_range(0, 99) < 10) out_take = 1;
                tick();
                check(out_valid == m_ovld, "R9 random", int'(out_valid), int'(m_ovld));
                check($signed(out_sum) == m_osum, "R4 random", int'($signed(out_sum)), m_osum);
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule